// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence of a single read or write burst, as found inside a synchronous DRAM or in a controller model of one. A start strobe captures a start column, a burst length code and a burst type. On the following cycles the block presents one column per beat and moves to the next beat on each cycle in which the advance enable is high.

Two orderings are available. The sequential ordering counts upward and wraps inside the aligned block of the burst length. The interleaved ordering XORs the beat number into the low bits of the start column. A full-page setting, legal only with the sequential ordering, walks through every column and wraps until something stops it.

A burst ends after its last beat, when the terminate input is asserted, or when a fresh start strobe replaces it. The outputs are the current column, a valid flag and a last-beat flag.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and whenever no burst is active, `colValid` and `lastBeat` are 0 and `colOut` reads 0.
- R2: The length code `burstLenCode` selects the burst length: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives full page. The codes 3'b100, 3'b101 and 3'b110 give 1 beat. The length and the type are captured at the start strobe and hold for the whole burst.
- R3: Sequential type (`burstInterleave` = 0) with length L: on beat n the low log2(L) bits of `colOut` equal (start low bits + n) mod L, and the upper bits equal those of the start column.
- R4: Interleaved type (`burstInterleave` = 1) with length L: on beat n `colOut` equals the start column with its low log2(L) bits XORed with n. Code 3'b111 combined with the interleaved type is illegal and gives 1 beat.
- R5: Full page with the sequential type: on beat n `colOut` = (start + n) mod 256. The sequence wraps from 255 to 0 and continues until a terminate or a new start. `lastBeat` is never 1 in this mode.
- R6: A start strobe sampled at a clock edge makes `colValid` 1 and `colOut` the start column (beat 0) from that edge onward. Each later edge with `advanceEn` high moves to the next beat. An edge with `advanceEn` low holds the beat.
- R7: For a fixed length L, `lastBeat` is 1 exactly on beat L-1. An edge with `advanceEn` high on that beat ends the burst, so `colValid` is 0 after it.
- R8: An edge with `terminate` high and no start strobe makes `colValid` 0 after that edge. No further beats appear until the next start.
- R9: A start strobe during an active burst abandons the old sequence and begins the new one at that edge. When the start strobe and `terminate` are both high, the start takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| startReq | input | 1 | Start strobe for a new burst |
| startCol | input | 8 | Start column, captured with the start strobe |
| burstLenCode | input | 3 | Burst length code |
| burstInterleave | input | 1 | 1 selects interleaved ordering, 0 selects sequential |
| advanceEn | input | 1 | Moves to the next beat at this edge |
| terminate | input | 1 | Ends the active burst |
| colOut | output | 8 | Column of the current beat, 0 when idle |
| colValid | output | 1 | A burst beat is being presented |
| lastBeat | output | 1 | The current beat is the final beat of a fixed-length burst |

## Verification
Sequential and interleaved bursts of every fixed length are started from columns with nonzero low bits. This separates wrap-in-block counting from plain increment and from XOR ordering, since the three orderings only agree when the start is aligned. A full-page run of more than 256 beats shows the wrap at 255 and that no last-beat flag appears. The illegal codes and the interleaved full-page combination show that these fall back to one beat. Stalls, terminates and restarts, including a restart on the same cycle as a terminate, are mixed in at random so that the per-cycle reference model is exercised against beat holding and mid-burst replacement.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  localparam int LEN_CODE_W  = 3;
  localparam int MAX_LEN_LOG = 3;  // longest fixed burst is 2**3 beats
  localparam int LEN_LOG_W   = 2;

  typedef struct packed {
    logic load;  // capture a new burst
    logic step;  // move to the next beat
  } colStrobe_t;

  typedef struct packed {
    logic                 fullPage;
    logic [LEN_LOG_W-1:0] lenLog;
  } burstCfg_t;

  function automatic burstCfg_t decodeLen(input logic [LEN_CODE_W-1:0] code,
                                          input logic interleave);
    burstCfg_t cfg;
    cfg.fullPage = 1'b0;
    cfg.lenLog   = '0;
    case (code)
      3'b001:  cfg.lenLog = 2'd1;
      3'b010:  cfg.lenLog = 2'd2;
      3'b011:  cfg.lenLog = 2'd3;
      3'b111:  cfg.fullPage = !interleave;  // illegal with interleave -> 1 beat
      default: cfg.lenLog = 2'd0;
    endcase
    return cfg;
  endfunction

endpackage

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startReq,
  input  logic [LEN_CODE_W-1:0] lenCode,
  input  logic                  interleave,
  input  logic                  advanceEn,
  input  logic                  terminate,
  output colStrobe_t            strobe,
  output logic                  active,
  output logic                  isLast
);

  localparam int REM_W = MAX_LEN_LOG;

  burstCfg_t        cfg;
  logic             activeQ;
  logic             fullQ;
  logic [REM_W-1:0] remainQ;

  assign cfg    = decodeLen(lenCode, interleave);
  assign active = activeQ;
  assign isLast = activeQ && !fullQ && (remainQ == '0);

  always_comb begin
    strobe.load = startReq;
    strobe.step = activeQ && advanceEn && !startReq && !terminate && !isLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      fullQ   <= 1'b0;
      remainQ <= '0;
    end else if (startReq) begin
      activeQ <= 1'b1;
      fullQ   <= cfg.fullPage;
      remainQ <= REM_W'((32'd1 << cfg.lenLog) - 32'd1);
    end else if (terminate) begin
      activeQ <= 1'b0;
    end else if (activeQ && advanceEn) begin
      if (isLast) begin
        activeQ <= 1'b0;
      end else if (!fullQ) begin
        remainQ <= remainQ - 1'b1;
      end
    end
  end

endmodule

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  colStrobe_t            strobe,
  input  logic [COL_W-1:0]      startCol,
  input  logic [LEN_CODE_W-1:0] lenCode,
  input  logic                  interleave,
  output logic [COL_W-1:0]      col
);

  burstCfg_t        cfg;
  logic [COL_W-1:0] loadMask;
  logic [COL_W-1:0] baseQ;
  logic [COL_W-1:0] beatQ;
  logic [COL_W-1:0] maskQ;
  logic             interQ;
  logic [COL_W-1:0] seqCol;
  logic [COL_W-1:0] xorCol;

  assign cfg = decodeLen(lenCode, interleave);

  always_comb begin
    for (int i = 0; i < COL_W; i++) begin
      loadMask[i] = cfg.fullPage || (i < int'(cfg.lenLog));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ  <= '0;
      beatQ  <= '0;
      maskQ  <= '0;
      interQ <= 1'b0;
    end else if (strobe.load) begin
      baseQ  <= startCol;
      beatQ  <= '0;
      maskQ  <= loadMask;
      interQ <= interleave;
    end else if (strobe.step) begin
      beatQ  <= beatQ + 1'b1;
    end
  end

  // a full-page mask covers every bit, so the sum wraps over the whole page
  assign seqCol = (baseQ & ~maskQ) | ((baseQ + beatQ) & maskQ);
  assign xorCol = baseQ ^ (beatQ & maskQ);
  assign col    = interQ ? xorCol : seqCol;

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       burstLenCode,
  input  logic             burstInterleave,
  input  logic             advanceEn,
  input  logic             terminate,
  output logic [COL_W-1:0] colOut,
  output logic             colValid,
  output logic             lastBeat
);

  colStrobe_t       strobe;
  logic             active;
  logic             isLast;
  logic [COL_W-1:0] dpCol;

  burst_col_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .lenCode    (burstLenCode),
    .interleave (burstInterleave),
    .advanceEn  (advanceEn),
    .terminate  (terminate),
    .strobe     (strobe),
    .active     (active),
    .isLast     (isLast)
  );

  burst_col_dp #(.COL_W(COL_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .startCol   (startCol),
    .lenCode    (burstLenCode),
    .interleave (burstInterleave),
    .col        (dpCol)
  );

  assign colOut   = active ? dpCol : '0;
  assign colValid = active;
  assign lastBeat = isLast;

endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             startReq,
  input logic [COL_W-1:0] startCol,
  input logic             advanceEn,
  input logic             terminate,
  input logic [COL_W-1:0] colOut,
  input logic             colValid,
  input logic             lastBeat
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !colValid |-> (colOut == '0) && !lastBeat);

  p_start_loads_r6: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> colValid && (colOut == $past(startCol)));

  p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    colValid && !advanceEn && !startReq && !terminate
      |=> colValid && $stable(colOut) && $stable(lastBeat));

  p_last_ends_r7: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat && advanceEn && !startReq && !terminate |=> !colValid);

  p_terminate_stops_r8: assert property (@(posedge clk) disable iff (!rstN)
    terminate && !startReq |=> !colValid);

  p_restart_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    colValid && startReq && terminate |=> colValid);

endmodule

bind burst_col_gen burst_col_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startReq  (startReq),
  .startCol  (startCol),
  .advanceEn (advanceEn),
  .terminate (terminate),
  .colOut    (colOut),
  .colValid  (colValid),
  .lastBeat  (lastBeat)
);

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic [7:0] startCol = '0;
  logic [2:0] burstLenCode = '0;
  logic       burstInterleave = 1'b0;
  logic       advanceEn = 1'b0;
  logic       terminate = 1'b0;
  logic [7:0] colOut;
  logic       colValid;
  logic       lastBeat;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  bit mActive = 0;
  int mBase = 0;
  int mBeat = 0;
  int mBl = 1;      // 0 means full page
  bit mInter = 0;

  always #2 clk = ~clk;  // 250 MHz

  burst_col_gen dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startCol(startCol),
    .burstLenCode(burstLenCode), .burstInterleave(burstInterleave),
    .advanceEn(advanceEn), .terminate(terminate),
    .colOut(colOut), .colValid(colValid), .lastBeat(lastBeat)
  );

  function automatic int lenOf(input logic [2:0] code, input bit inter);
    case (code)
      3'b001:  return 2;
      3'b010:  return 4;
      3'b011:  return 8;
      3'b111:  return inter ? 1 : 0;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mActive = 0;
    end else if (startReq) begin
      mActive = 1;
      mBase = int'(startCol);
      mBeat = 0;
      mInter = burstInterleave;
      mBl = lenOf(burstLenCode, burstInterleave);
    end else if (terminate) begin
      mActive = 0;
    end else if (mActive && advanceEn) begin
      if (mBl != 0 && mBeat == mBl - 1) mActive = 0;
      else mBeat = (mBeat + 1) % 256;
    end
  end

  function automatic int expCol();
    int mask;
    if (!mActive) return 0;
    if (mBl == 0) return (mBase + mBeat) % 256;
    mask = mBl - 1;
    if (mInter) return mBase ^ mBeat;
    return (mBase & ~mask & 255) | ((mBase + mBeat) & mask);
  endfunction

  task automatic compare(input string tag);
    bit eLast;
    int eCol;
    eLast = mActive && mBl != 0 && mBeat == mBl - 1;
    eCol  = expCol();
    checks++;
    if (colValid !== mActive) begin
      errors++;
      $display("FAIL %s colValid actual %0b expected %0b", tag, colValid, mActive);
    end
    checks++;
    if (lastBeat !== eLast) begin
      errors++;
      $display("FAIL %s lastBeat actual %0b expected %0b", tag, lastBeat, eLast);
    end
    checks++;
    if (int'(colOut) != eCol || $isunknown(colOut)) begin
      errors++;
      $display("FAIL %s colOut actual %0h expected %0h", tag, colOut, eCol);
    end
  endtask

  // drive at the falling edge, let one rising edge pass, compare at the next fall
  task automatic cyc(input string tag, input bit s, input int c, input int code,
                     input bit inter, input bit adv, input bit term);
    startReq = s;
    startCol = 8'(c);
    burstLenCode = 3'(code);
    burstInterleave = inter;
    advanceEn = adv;
    terminate = term;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic burst(input string tag, input int c, input int code,
                       input bit inter, input int n);
    cyc(tag, 1, c, code, inter, 1, 0);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0, 1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog expired actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    compare("R1");
    cyc("R1", 0, 0, 0, 0, 0, 0);
    rstN = 1'b1;
    cyc("R1", 0, 0, 0, 0, 1, 0);
    cyc("R1", 0, 0, 0, 0, 1, 1);

    // sequential fixed lengths from unaligned starts (R2, R3, R7)
    for (int code = 0; code < 4; code++) begin
      burst("R3", 8'h2D, code, 0, 10);
      burst("R3", 8'hFE, code, 0, 10);
    end
    // interleaved fixed lengths (R2, R4, R7)
    for (int code = 0; code < 4; code++) begin
      burst("R4", 8'h2D, code, 1, 10);
      burst("R4", 8'h96, code, 1, 10);
    end
    // unused codes and interleaved full page fall back to one beat (R2, R4)
    for (int code = 4; code < 7; code++) burst("R2", 8'h37, code, 0, 3);
    burst("R4", 8'h37, 7, 1, 3);

    // full page through the wrap, then terminate (R5, R8)
    burst("R5", 8'hF0, 7, 0, 300);
    cyc("R8", 0, 0, 0, 0, 1, 1);
    cyc("R8", 0, 0, 0, 0, 1, 0);
    cyc("R8", 0, 0, 0, 0, 1, 0);

    // stall mid-burst (R6)
    cyc("R6", 1, 8'h45, 3, 0, 0, 0);
    cyc("R6", 0, 0, 0, 0, 0, 0);
    cyc("R6", 0, 0, 0, 0, 1, 0);
    cyc("R6", 0, 0, 0, 0, 0, 0);
    cyc("R6", 0, 0, 0, 0, 1, 0);
    // terminate mid-burst (R8)
    cyc("R8", 0, 0, 0, 0, 1, 1);
    cyc("R8", 0, 0, 0, 0, 1, 0);
    // restart mid-burst, then restart with a terminate on the same edge (R9)
    cyc("R9", 1, 8'h10, 3, 0, 1, 0);
    cyc("R9", 0, 0, 0, 0, 1, 0);
    cyc("R9", 1, 8'hA3, 2, 1, 1, 0);
    cyc("R9", 0, 0, 0, 0, 1, 0);
    cyc("R9", 1, 8'h5C, 7, 0, 1, 1);
    for (int i = 0; i < 5; i++) cyc("R9", 0, 0, 0, 0, 1, 0);
    cyc("R9", 0, 0, 0, 0, 1, 1);

    // mixed traffic: stalls, restarts, terminates in random order (R6)
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      cyc("R6", r < 8, int'($urandom_range(0, 255)), int'($urandom_range(0, 7)),
          bit'($urandom_range(0, 1)), r >= 25, r >= 96);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule